// File: doc/BRIEF.md
# Fair Test-and-Set Lock Bank

This block holds a set of hardware lock registers that a group of processing cores share to guard critical sections. Each core has its own request port. On it the core presents a lock number and an operation, either take or drop, and one cycle later it reads back whether the operation succeeded. A take works like a test-and-set: the old state of the lock is read and the lock is set in the same step. A core whose take fails spins by issuing the same take again until it wins.

Each lock keeps its own owner and its own rotating priority pointer. When several cores ask for the same free lock in one cycle, the pointer decides which one wins. After each grant the pointer moves to the core that follows the winner, so every core that keeps spinning is served in turn. Separate locks act independently, so one lock can guard an enqueue path while another guards a dequeue path, and both can be granted in the same cycle.

Top module: `lockbank_top`

## Requirements
- R1: After reset every lock is free and has no owner, every priority pointer selects core 0, and all response outputs are low.
- R2: A take on a free lock succeeds. The response shows `rsp_ok`=1 and `rsp_err`=0, and the requesting core becomes the owner.
- R3: A take on a held lock fails with `rsp_ok`=0 and `rsp_err`=0 and leaves the owner unchanged. This includes a take by the core that already owns the lock.
- R4: Each response is registered. `rsp_vld[c]` equals `req_vld[c]` from the previous cycle, and `rsp_ok` and `rsp_err` are never both high for one core.
- R5: At most one core is granted any one lock in a cycle. Takes on different locks in the same cycle are resolved independently.
- R6: Among the cores taking the same free lock, the grant goes to the first requester at or after the lock's pointer, counting upward and wrapping from core NCORE-1 to core 0. After a grant the pointer moves to the winner plus one, wrapping in the same way.
- R7: A drop by the current owner succeeds with `rsp_ok`=1 and frees the lock.
- R8: A drop by a core that does not own the lock, or a drop on a free lock, is ignored. It gives `rsp_err`=1 and `rsp_ok`=0, and the lock's owner does not change.
- R9: When the owner drops a lock in the same cycle as other cores take it, the drop is applied first, and one of the takers is granted in that same cycle.
- R10: Encoding: `req_op[c]`=0 means take and 1 means drop. Core c's lock number sits in `req_idx[c*LW +: LW]`, where LW=$clog2(NLOCK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NCORE | Request valid, one bit per core |
| req_op | input | NCORE | Operation per core: 0 = take, 1 = drop |
| req_idx | input | NCORE*LW | Lock number per core, packed by core |
| rsp_vld | output | NCORE | Response valid, one cycle after the request |
| rsp_ok | output | NCORE | Take granted, or drop accepted |
| rsp_err | output | NCORE | Drop rejected because the core is not the owner |

## Verification
Two functions can land in the same cycle: the owner's drop and other cores' takes on the same lock. A bench that sends them in separate cycles would never reach the release-first path. The bench therefore passes one lock around all eight cores. In each cycle the holder drops the lock while every other core takes it, and the check is that in that one response cycle the holder sees its drop accepted and exactly the core after it sees a grant. Grant arbitration and the pointer update also collide when two locks are contested in the same cycle, and that case is judged by which core wins on each lock, worked out from the pointer history.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;
  typedef enum logic {
    OP_TAKE = 1'b0,
    OP_DROP = 1'b1
  } lk_op_e;
endpackage

// File: rtl/lockbank_rr.sv
module lockbank_rr #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] start,
  output logic         hit,
  output logic [W-1:0] pick,
  output logic [N-1:0] onehot
);
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] a, input int unsigned k);
    logic [W:0] s;
    s = {1'b0, a} + (W+1)'(k);
    if (s >= (W+1)'(N)) s = s - (W+1)'(N);
    return s[W-1:0];
  endfunction

  always_comb begin
    hit  = 1'b0;
    pick = start;
    for (int unsigned k = 0; k < N; k++) begin
      if (!hit && req[wrap_add(start, k)]) begin
        hit  = 1'b1;
        pick = wrap_add(start, k);
      end
    end
    onehot = '0;
    if (hit) onehot[pick] = 1'b1;
  end
endmodule

// File: rtl/lockbank_slot.sv
module lockbank_slot #(
  parameter int NCORE = 8,
  localparam int CW = $clog2(NCORE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCORE-1:0] acq_mask,
  input  logic [NCORE-1:0] rel_mask,
  output logic [NCORE-1:0] gnt_vec,
  output logic [NCORE-1:0] rel_ok_vec
);
  logic          busy;
  logic [CW-1:0] owner;
  logic [CW-1:0] ptr;
  logic          rel_hit;
  logic          free_now;
  logic          hit;
  logic [CW-1:0] pick;
  logic [NCORE-1:0] arb_req;

  assign rel_hit  = busy && rel_mask[owner];
  assign free_now = !busy || rel_hit;
  assign arb_req  = free_now ? acq_mask : '0;

  lockbank_rr #(.N(NCORE)) u_rr (
    .req    (arb_req),
    .start  (ptr),
    .hit    (hit),
    .pick   (pick),
    .onehot (gnt_vec)
  );

  always_comb begin
    rel_ok_vec = '0;
    if (rel_hit) rel_ok_vec[owner] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      owner <= '0;
      ptr   <= '0;
    end else if (hit) begin
      busy  <= 1'b1;
      owner <= pick;
      ptr   <= (pick == CW'(NCORE-1)) ? '0 : pick + 1'b1;
    end else if (rel_hit) begin
      busy  <= 1'b0;
    end
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_vec) && ((gnt_vec & ~acq_mask) == '0));

  assert_grant_when_free_R3: assert property (@(posedge clk) disable iff (rst)
    (|gnt_vec) |-> (!busy || rel_hit));

  assert_hold_owner_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !rel_hit) |=> (busy && $stable(owner)));

  assert_release_first_R9: assert property (@(posedge clk) disable iff (rst)
    (rel_hit && (|acq_mask)) |-> (|gnt_vec));
endmodule

// File: rtl/lockbank_top.sv
module lockbank_top #(
  parameter int NCORE = 8,
  parameter int NLOCK = 8,
  localparam int LW = $clog2(NLOCK)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCORE-1:0]    req_vld,
  input  logic [NCORE-1:0]    req_op,
  input  logic [NCORE*LW-1:0] req_idx,
  output logic [NCORE-1:0]    rsp_vld,
  output logic [NCORE-1:0]    rsp_ok,
  output logic [NCORE-1:0]    rsp_err
);
  import lockbank_pkg::*;

  logic [NCORE-1:0] acq_m  [NLOCK];
  logic [NCORE-1:0] rel_m  [NLOCK];
  logic [NCORE-1:0] gnt_m  [NLOCK];
  logic [NCORE-1:0] relok_m[NLOCK];
  logic [NCORE-1:0] ok_now;
  logic [NCORE-1:0] is_drop;

  always_comb begin
    for (int c = 0; c < NCORE; c++) is_drop[c] = (lk_op_e'(req_op[c]) == OP_DROP);
  end

  for (genvar l = 0; l < NLOCK; l++) begin : g_lock
    always_comb begin
      for (int c = 0; c < NCORE; c++) begin
        acq_m[l][c] = req_vld[c] && !is_drop[c] && (req_idx[c*LW +: LW] == LW'(l));
        rel_m[l][c] = req_vld[c] &&  is_drop[c] && (req_idx[c*LW +: LW] == LW'(l));
      end
    end

    lockbank_slot #(.NCORE(NCORE)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .acq_mask   (acq_m[l]),
      .rel_mask   (rel_m[l]),
      .gnt_vec    (gnt_m[l]),
      .rel_ok_vec (relok_m[l])
    );
  end

  always_comb begin
    ok_now = '0;
    for (int l = 0; l < NLOCK; l++) ok_now = ok_now | gnt_m[l] | relok_m[l];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld <= '0;
      rsp_ok  <= '0;
      rsp_err <= '0;
    end else begin
      rsp_vld <= req_vld;
      rsp_ok  <= ok_now;
      rsp_err <= req_vld & is_drop & ~ok_now;
    end
  end

  assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rsp_vld == $past(req_vld)));

  assert_ok_err_excl_R4: assert property (@(posedge clk) disable iff (rst)
    ((rsp_ok & rsp_err) == '0) && (((rsp_ok | rsp_err) & ~rsp_vld) == '0));

  assert_err_only_drop_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rsp_err & ~$past(req_op)) == '0));
endmodule

// File: tb/lockbank_top_test.sv
`timescale 1ns/1ps
module lockbank_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req_vld = '0;
  logic [7:0]  req_op = '0;
  logic [23:0] req_idx = '0;
  logic [7:0]  rsp_vld, rsp_ok, rsp_err;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  lockbank_top uut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_op(req_op), .req_idx(req_idx),
    .rsp_vld(rsp_vld), .rsp_ok(rsp_ok), .rsp_err(rsp_err)
  );

  function automatic logic [23:0] same_idx(input int l);
    logic [23:0] r;
    for (int c = 0; c < 8; c++) r[c*3 +: 3] = 3'(l);
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] v, input logic [7:0] o,
                      input logic [23:0] ix, input logic [7:0] eok, input logic [7:0] eerr);
    @(negedge clk);
    req_vld = v; req_op = o; req_idx = ix;
    @(posedge clk);
    #2;
    cmp({tag, " R4 vld"}, rsp_vld, v);
    cmp({tag, " ok"}, rsp_ok, eok);
    cmp({tag, " err"}, rsp_err, eerr);
    @(negedge clk);
    req_vld = '0; req_op = '0; req_idx = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    cmp("R1 reset vld", rsp_vld, 8'h00);
    cmp("R1 reset ok", rsp_ok, 8'h00);
    cmp("R1 reset err", rsp_err, 8'h00);
  endtask

  task automatic t_parallel;
    logic [23:0] ix;
    for (int c = 0; c < 8; c++) ix[c*3 +: 3] = 3'(c);
    step("R1 R2 R5 R10 take own lock", 8'hFF, 8'h00, ix, 8'hFF, 8'h00);
    step("R7 R10 drop own lock", 8'hFF, 8'hFF, ix, 8'hFF, 8'h00);
  endtask

  task automatic t_owner_rules;
    step("R2 core3 takes lock2", 8'h08, 8'h00, same_idx(2), 8'h08, 8'h00);
    step("R3 core5 take held", 8'h20, 8'h00, same_idx(2), 8'h00, 8'h00);
    step("R3 owner retake", 8'h08, 8'h00, same_idx(2), 8'h00, 8'h00);
    step("R8 core5 foreign drop", 8'h20, 8'h20, same_idx(2), 8'h00, 8'h20);
    step("R8 lock still held", 8'h20, 8'h00, same_idx(2), 8'h00, 8'h00);
    step("R7 owner drop", 8'h08, 8'h08, same_idx(2), 8'h08, 8'h00);
    step("R8 drop free lock7", 8'h01, 8'h01, same_idx(7), 8'h00, 8'h01);
    step("R2 lock7 still free", 8'h01, 8'h00, same_idx(7), 8'h01, 8'h00);
    step("R7 drop lock7", 8'h01, 8'h01, same_idx(7), 8'h01, 8'h00);
  endtask

  task automatic t_wrap;
    // lock0 pointer is 1 after t_parallel
    step("R6 pick 5 from ptr1", 8'h21, 8'h00, same_idx(0), 8'h20, 8'h00);
    step("R7 core5 drop", 8'h20, 8'h20, same_idx(0), 8'h20, 8'h00);
    step("R6 wrap pick 0 from ptr6", 8'h21, 8'h00, same_idx(0), 8'h01, 8'h00);
    step("R7 core0 drop", 8'h01, 8'h01, same_idx(0), 8'h01, 8'h00);
  endtask

  task automatic t_handoff;
    int h;
    // lock1 pointer is 2 after t_parallel
    step("R5 R6 all take lock1", 8'hFF, 8'h00, same_idx(1), 8'h04, 8'h00);
    h = 2;
    for (int i = 0; i < 8; i++) begin
      logic [7:0] hb, nb;
      hb = 8'(1 << h);
      nb = 8'(1 << ((h + 1) % 8));
      step("R9 R6 handoff", 8'hFF, hb, same_idx(1), hb | nb, 8'h00);
      h = (h + 1) % 8;
    end
    step("R7 final drop lock1", 8'(1 << h), 8'(1 << h), same_idx(1), 8'(1 << h), 8'h00);
  endtask

  task automatic t_two_locks;
    logic [23:0] ix;
    ix = '0;
    ix[0*3 +: 3] = 3'd3; ix[1*3 +: 3] = 3'd3;
    ix[2*3 +: 3] = 3'd4; ix[3*3 +: 3] = 3'd4;
    // lock3 ptr 4 -> wraps to core0; lock4 ptr 5 -> wraps to core2
    step("R5 R6 two locks contended", 8'h0F, 8'h00, ix, 8'h05, 8'h00);
    step("R4 idle cycle", 8'h00, 8'h00, '0, 8'h00, 8'h00);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    t_reset();
    t_parallel();
    t_owner_rules();
    t_wrap();
    t_handoff();
    t_two_locks();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule